// File: doc/BRIEF.md
# Four-Bit Arithmetic and Boolean Function Unit

This block is a purely combinational slice that works on two four-bit operands. Four select lines and a mode line together choose one of 32 operations. With the mode line high, every result bit is a two-input Boolean function of the matching operand bits, and no carry crosses between bits. With the mode line low, the slice adds two operand-derived terms and the incoming carry, and so provides addition, subtraction, increment and decrement, doubling and transfer.

Slices are chained in two ways. The simple way feeds each slice's ripple carry output into the next slice's carry input. The fast way takes the group generate and group propagate outputs to an external lookahead unit. Inside the slice, all carries are formed as flat sum-of-products terms rather than by a ripple chain. Operand and result data are active-high. The ripple carry input, the ripple carry output and both group outputs are active-low.

Subtraction adds the bitwise complement of B to A. With no carry in, the result is A - B - 1, and asserting the carry input gives A - B. An equality flag is decoded from an all-ones result, so in subtract mode with no carry in it reports A == B.

Top module: `alu4_slice`

## Requirements
- R1: With mode_i = 1, f_o follows the select code sel_i[3:0] as follows: 0000 ~A, 0001 ~(A|B), 0010 ~A&B, 0011 0000, 0100 ~(A&B), 0101 ~B, 0110 A^B, 0111 A&~B, 1000 ~A|B, 1001 ~(A^B), 1010 B, 1011 A&B, 1100 1111, 1101 A|~B, 1110 A|B, 1111 A.
- R2: With mode_i = 0 and cin_n_i = 1 (no carry in), f_o is the low four bits of U + V. The pair (U, V) for each sel_i is: 0000 (A,0), 0001 (A|B,0), 0010 (A|~B,0), 0011 (1111,0), 0100 (A,A&~B), 0101 (A|B,A&~B), 0110 (A|~B,A&~B), 0111 (1111,A&~B), 1000 (A,A&B), 1001 (A|B,A&B), 1010 (A|~B,A&B), 1011 (1111,A&B), 1100 (A,A), 1101 (A|B,A), 1110 (A|~B,A), 1111 (1111,A).
- R3: With mode_i = 0 and cin_n_i = 0, f_o is the low four bits of U + V + 1.
- R4: cout_n_o is 0 exactly when U + V + (carry in) is 16 or more, where the carry in is 1 when cin_n_i = 0.
- R5: gen_n_o is 0 exactly when U + V is 16 or more.
- R6: prop_n_o is 0 exactly when every bit of U|V is 1.
- R7: equal_o is 1 exactly when f_o = 1111, in either mode.
- R8: With sel_i = 0110, mode_i = 0 and cin_n_i = 1, equal_o = 1 exactly when A == B, and cout_n_o = 0 exactly when A > B as unsigned numbers.
- R9: With mode_i = 1, f_o does not depend on cin_n_i.
- R10: cout_n_o, gen_n_o and prop_n_o do not depend on mode_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 4 | Operand A |
| b_i | input | 4 | Operand B |
| sel_i | input | 4 | Function select code |
| mode_i | input | 1 | 1 = Boolean functions, 0 = arithmetic |
| cin_n_i | input | 1 | Ripple carry in, active-low |
| f_o | output | 4 | Result |
| cout_n_o | output | 1 | Ripple carry out of bit 3, active-low |
| gen_n_o | output | 1 | Group carry generate, active-low |
| prop_n_o | output | 1 | Group carry propagate, active-low |
| equal_o | output | 1 | High when the result is all ones |

## Verification
The hardest outputs to reach are the group propagate and group generate terms when a carry arises from the internal sum rather than from the incoming carry. Examples are a sum of exactly 15 with carry in 1 (propagate only) and a generate in bit 0 that must travel through three propagating bits. Directed tests rarely hit these points. The stimulus therefore sweeps every combination of operands, select code, mode and carry in, 16384 vectors in all. A separate compare-mode pass checks equality and magnitude against plain integer comparison.

// File: rtl/alu4_pkg.sv
package alu4_pkg;
  localparam int unsigned SLICE_W = 4;
  localparam int unsigned SEL_W   = 4;

  typedef struct packed {
    logic [SLICE_W-1:0] x;  // per-bit propagate term (first addend)
    logic [SLICE_W-1:0] y;  // per-bit generate term (second addend)
  } bit_terms_t;
endpackage

// File: rtl/alu4_bit_terms.sv
module alu4_bit_terms
  import alu4_pkg::*;
#(
  parameter int unsigned W = SLICE_W
) (
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  input  logic [SEL_W-1:0] sel,
  output logic [W-1:0]     x,
  output logic [W-1:0]     y
);
  // sel[1:0] picks the first addend, sel[3:2] picks the second addend
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      x[i] = a[i] | (b[i] & sel[0]) | (~b[i] & sel[1]);
      y[i] = (a[i] & ~b[i] & sel[2]) | (a[i] & b[i] & sel[3]);
    end

    // the second addend is never set where the first is clear
    always_comb begin
      p_gen_within_prop_r5: assert (!(y[i] && !x[i]))
        else $error("generate term outside propagate term at bit %0d", i);
    end
  end
endmodule

// File: rtl/alu4_carry_lookahead.sv
module alu4_carry_lookahead
  import alu4_pkg::*;
#(
  parameter int unsigned W = SLICE_W
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         c0,
  output logic [W:0]   carry,
  output logic         grp_gen,
  output logic         grp_prop
);
  // product of x over bit span [lo..hi]; empty span yields 1
  function automatic logic span_and(input logic [W-1:0] v, input int lo, input int hi);
    logic r;
    r = 1'b1;
    for (int k = 0; k < W; k++) begin
      if (k >= lo && k <= hi) r = r & v[k];
    end
    return r;
  endfunction

  assign carry[0] = c0;

  for (genvar i = 0; i < W; i++) begin : g_carry
    always_comb begin
      logic acc;
      acc = c0 & span_and(x, 0, i);
      for (int j = 0; j <= i; j++) begin
        acc = acc | (y[j] & span_and(x, j + 1, i));
      end
      carry[i+1] = acc;
    end

    // flat lookahead must agree with a one-bit ripple step
    always_comb begin
      p_carry_step_r4: assert (carry[i+1] == (y[i] | (x[i] & carry[i])))
        else $error("carry mismatch into bit %0d", i + 1);
    end
  end

  always_comb begin
    logic g;
    g = 1'b0;
    for (int j = 0; j < W; j++) begin
      g = g | (y[j] & span_and(x, j + 1, W - 1));
    end
    grp_gen  = g;
    grp_prop = span_and(x, 0, W - 1);
  end

  always_comb begin
    p_gen_forces_cout_r5: assert (!grp_gen || carry[W])
      else $error("group generate without carry out");
    p_prop_passes_cin_r6: assert (!(grp_prop && c0) || carry[W])
      else $error("propagated carry in lost");
  end
endmodule

// File: rtl/alu4_result_stage.sv
module alu4_result_stage
  import alu4_pkg::*;
#(
  parameter int unsigned W = SLICE_W
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] carry,
  input  logic         logic_mode,
  output logic [W-1:0] f,
  output logic         all_ones
);
  logic [W-1:0] half_sum;

  for (genvar i = 0; i < W; i++) begin : g_res
    always_comb begin
      half_sum[i] = x[i] ^ y[i];
      f[i] = logic_mode ? ~half_sum[i] : (half_sum[i] ^ carry[i]);
    end
  end

  assign all_ones = &f;
endmodule

// File: rtl/alu4_slice.sv
module alu4_slice
  import alu4_pkg::*;
#(
  parameter int unsigned W = SLICE_W
) (
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             mode_i,
  input  logic             cin_n_i,
  output logic [W-1:0]     f_o,
  output logic             cout_n_o,
  output logic             gen_n_o,
  output logic             prop_n_o,
  output logic             equal_o
);
  localparam logic [SEL_W-1:0] SEL_SUB = 4'b0110;

  logic [W-1:0] x_t, y_t;
  logic [W:0]   carry_t;
  logic         gen_t, prop_t;

  alu4_bit_terms #(.W(W)) u_terms (
    .a(a_i), .b(b_i), .sel(sel_i), .x(x_t), .y(y_t)
  );

  alu4_carry_lookahead #(.W(W)) u_cla (
    .x(x_t), .y(y_t), .c0(~cin_n_i),
    .carry(carry_t), .grp_gen(gen_t), .grp_prop(prop_t)
  );

  alu4_result_stage #(.W(W)) u_res (
    .x(x_t), .y(y_t), .carry(carry_t[W-1:0]), .logic_mode(mode_i),
    .f(f_o), .all_ones(equal_o)
  );

  assign cout_n_o = ~carry_t[W];
  assign gen_n_o  = ~gen_t;
  assign prop_n_o = ~prop_t;

  always_comb begin
    if (!mode_i && sel_i == SEL_SUB && cin_n_i) begin
      p_compare_eq_r8: assert (equal_o == (a_i == b_i))
        else $error("compare equality wrong");
      p_compare_mag_r8: assert (cout_n_o == !(a_i > b_i))
        else $error("compare magnitude wrong");
    end
  end
endmodule

// File: tb/alu4_slice_bench.sv
module alu4_slice_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] a, b, sel;
  logic mode, cin_n;
  logic [3:0] f;
  logic cout_n, gen_n, prop_n, equal;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  alu4_slice u_alu4_slice (
    .a_i(a), .b_i(b), .sel_i(sel), .mode_i(mode), .cin_n_i(cin_n),
    .f_o(f), .cout_n_o(cout_n), .gen_n_o(gen_n), .prop_n_o(prop_n), .equal_o(equal)
  );

  task automatic addends(input logic [3:0] s, input logic [3:0] aa, input logic [3:0] bb,
                         output logic [3:0] u, output logic [3:0] v);
    case (s)
      4'b0000: begin u = aa;        v = 4'h0;      end
      4'b0001: begin u = aa | bb;   v = 4'h0;      end
      4'b0010: begin u = aa | ~bb;  v = 4'h0;      end
      4'b0011: begin u = 4'hF;      v = 4'h0;      end
      4'b0100: begin u = aa;        v = aa & ~bb;  end
      4'b0101: begin u = aa | bb;   v = aa & ~bb;  end
      4'b0110: begin u = aa | ~bb;  v = aa & ~bb;  end
      4'b0111: begin u = 4'hF;      v = aa & ~bb;  end
      4'b1000: begin u = aa;        v = aa & bb;   end
      4'b1001: begin u = aa | bb;   v = aa & bb;   end
      4'b1010: begin u = aa | ~bb;  v = aa & bb;   end
      4'b1011: begin u = 4'hF;      v = aa & bb;   end
      4'b1100: begin u = aa;        v = aa;        end
      4'b1101: begin u = aa | bb;   v = aa;        end
      4'b1110: begin u = aa | ~bb;  v = aa;        end
      default: begin u = 4'hF;      v = aa;        end
    endcase
  endtask

  function automatic logic [3:0] bool_ref(input logic [3:0] s, input logic [3:0] aa, input logic [3:0] bb);
    case (s)
      4'b0000: return ~aa;
      4'b0001: return ~(aa | bb);
      4'b0010: return ~aa & bb;
      4'b0011: return 4'h0;
      4'b0100: return ~(aa & bb);
      4'b0101: return ~bb;
      4'b0110: return aa ^ bb;
      4'b0111: return aa & ~bb;
      4'b1000: return ~aa | bb;
      4'b1001: return ~(aa ^ bb);
      4'b1010: return bb;
      4'b1011: return aa & bb;
      4'b1100: return 4'hF;
      4'b1101: return aa | ~bb;
      4'b1110: return aa | bb;
      default: return aa;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h (a=%h b=%h s=%b m=%b cn=%b)",
               req, what, act, exp, a, b, sel, mode, cin_n);
    end
  endtask

  task automatic apply(input logic [3:0] aa, input logic [3:0] bb, input logic [3:0] s,
                       input logic m, input logic cn);
    @(posedge clk);
    a = aa; b = bb; sel = s; mode = m; cin_n = cn;
    @(negedge clk);
  endtask

  // full comparison against the reference for the applied vector
  task automatic check_vector;
    logic [3:0] u, v, exp_f;
    logic [4:0] sum, raw;
    addends(sel, a, b, u, v);
    raw = {1'b0, u} + {1'b0, v};
    sum = raw + {4'b0, ~cin_n};
    if (mode) begin
      exp_f = bool_ref(sel, a, b);
      check(f == exp_f, "R1", "logic result", f, exp_f);
    end else if (cin_n) begin
      exp_f = sum[3:0];
      check(f == exp_f, "R2", "arith result", f, exp_f);
    end else begin
      exp_f = sum[3:0];
      check(f == exp_f, "R3", "arith result with carry", f, exp_f);
    end
    check(cout_n == ~sum[4], "R4", "carry out", cout_n, ~sum[4]);
    check(gen_n == ~raw[4], "R5", "group generate", gen_n, ~raw[4]);
    check(prop_n == ~(&(u | v)), "R6", "group propagate", prop_n, ~(&(u | v)));
    check(equal == (exp_f == 4'hF), "R7", "equality", equal, exp_f == 4'hF);
  endtask

  task automatic t_quiescent;
    apply(4'h0, 4'h0, 4'h0, 1'b0, 1'b1);
    check(f == 4'h0 && cout_n && gen_n && !prop_n == 1'b0 && !equal,
          "R2", "idle vector", {cout_n, gen_n, prop_n, equal, f}, 8'hE0);
  endtask

  task automatic t_logic_sweep;
    for (int v = 0; v < 4096; v++) begin
      apply(v[3:0], v[7:4], v[11:8], 1'b1, 1'b1);
      check_vector();
    end
  endtask

  task automatic t_arith_sweep;
    for (int v = 0; v < 8192; v++) begin
      apply(v[3:0], v[7:4], v[11:8], 1'b0, v[12]);
      check_vector();
    end
  endtask

  // R9 and R10: flip carry in under logic mode, flip mode, watch outputs
  task automatic t_independence;
    logic [3:0] f_first;
    logic [2:0] cg_first;
    for (int v = 0; v < 4096; v++) begin
      apply(v[3:0], v[7:4], v[11:8], 1'b1, 1'b1);
      f_first = f;
      cg_first = {cout_n, gen_n, prop_n};
      apply(v[3:0], v[7:4], v[11:8], 1'b1, 1'b0);
      check(f == f_first, "R9", "logic result vs carry in", f, f_first);
      apply(v[3:0], v[7:4], v[11:8], 1'b0, 1'b1);
      check({cout_n, gen_n, prop_n} == cg_first, "R10", "carry terms vs mode",
            {cout_n, gen_n, prop_n}, cg_first);
    end
  endtask

  task automatic t_compare;
    for (int v = 0; v < 256; v++) begin
      apply(v[3:0], v[7:4], 4'b0110, 1'b0, 1'b1);
      check(equal == (v[3:0] == v[7:4]), "R8", "compare equal", equal, v[3:0] == v[7:4]);
      check(cout_n == !(v[3:0] > v[7:4]), "R8", "compare magnitude", cout_n, !(v[3:0] > v[7:4]));
    end
  endtask

  task automatic t_corners;
    apply(4'hF, 4'h0, 4'b1001, 1'b0, 1'b0);   // 15 + 0 + 1 wraps
    check(f == 4'h0 && cout_n == 1'b0, "R3", "wrap with carry in", {cout_n, f}, 5'h00);
    check(gen_n == 1'b1 && prop_n == 1'b0, "R6", "propagate only", {gen_n, prop_n}, 2'b10);
    apply(4'h9, 4'h9, 4'b0110, 1'b0, 1'b0);   // A - B with forced carry
    check(f == 4'h0 && cout_n == 1'b0, "R3", "exact subtract", {cout_n, f}, 5'h00);
    apply(4'h8, 4'h8, 4'b1001, 1'b0, 1'b1);   // generate at top bit
    check(gen_n == 1'b0 && f == 4'h0, "R5", "top generate", {gen_n, f}, 5'h00);
  endtask

  initial begin
    a = '0; b = '0; sel = '0; mode = 1'b0; cin_n = 1'b1;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_quiescent();
    t_corners();
    t_compare();
    t_logic_sweep();
    t_arith_sweep();
    t_independence();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule